// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block is a Clause-22 style station-management master. Software sets a management enable input. It then presents one 32-bit frame word with a single-cycle write strobe. The engine sends a preamble of ones on the serial data line. It follows with the 32 frame bits, most significant first, clocked by a management clock that it derives from the system clock.

On a read operation the engine stops driving the data line from the turnaround field onward. It then samples 16 bits from the PHY into the low half of its frame register. Software polls the idle output to learn when the frame has finished. After a read it takes the returned data from the frame register.

The frame word layout is fixed, because the bits leave in this order:

| Bits | Field |
|------|-------|
| [31:30] | start code, 01 |
| [29:28] | operation: 01 write, 10 read |
| [27:23] | PHY address |
| [22:18] | register address |
| [17:16] | turnaround code, 10 |
| [15:0] | data |

Software supplies the start and turnaround codes, and the engine sends them as written. Any operation code other than 10 is treated as a write.

The management clock period is BASE_DIV << clk_div_sel system clocks. With the default BASE_DIV of 8 the choices are 8, 16, 32 and 64. Software picks the smallest divider that keeps the management clock in range. For a system clock below 20 MHz that divider is 8, below 40 MHz it is 16, below 80 MHz it is 32, and otherwise it is 64.

Top module: `mdio_frame_engine`

## Requirements
- R1: After reset, idle is 1, mdc is 0, mdio_oe is 0 and frame_q is zero.
- R2: A frame_wr pulse accepted while mgmt_en is 1 and idle is 1 loads frame_wdata into frame_q and drives idle to 0 from the next cycle on.
- R3: A frame_wr pulse while mgmt_en is 0 is ignored: idle stays 1 and frame_q keeps its value.
- R4: A frame_wr pulse while a frame is in flight is ignored: the frame on the line and frame_q[31:16] stay those of the first frame.
- R5: mdc is low at launch and low while idle. It toggles every (BASE_DIV << s)/2 clocks, where s is the clk_div_sel value latched at launch. Later changes to clk_div_sel have no effect on the running frame.
- R6: The line carries PRE_BITS ones and then frame bits 31 down to 0. Each bit lasts one mdc period, and mdio_o and the bit position change only at a falling edge of mdc.
- R7: For a write (operation not 10), mdio_oe is 1 for every bit period of the frame.
- R8: For a read (bits [29:28] = 10), mdio_oe is 1 up to the end of frame bit 18. It is 0 from the turnaround field (frame bit 17) to the end of the frame.
- R9: For a read, mdio_i is sampled at the rising mdc edge of each of the 16 data bit periods, first sample most significant. When idle returns, the samples sit in frame_q[15:0] and frame_q[31:16] is unchanged.
- R10: A frame lasts PRE_BITS+32 mdc periods. With mgmt_en held high, idle returns to 1 exactly (PRE_BITS+32) * (BASE_DIV << s) clocks after the launch edge.
- R11: While mgmt_en is 0 during a frame, mdc, the bit position and the outputs hold. The frame resumes where it stopped when mgmt_en returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mgmt_en | input | 1 | Management enable; gates launch and shifting |
| clk_div_sel | input | SEL_W | Management clock divider select, latched at launch |
| frame_wr | input | 1 | One-cycle frame word write strobe |
| frame_wdata | input | 32 | Frame word to send |
| frame_q | output | 32 | Frame register; holds read data after a read |
| idle | output | 1 | High when no frame is in flight |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Output enable for the serial data line |
| mdio_i | input | 1 | Serial data in from the line |

## Verification
The embedded properties watch, on every cycle, that the bit position moves only after a falling management clock edge. They also watch that mdc holds while the engine is paused and that the line is quiet while idle. Further properties cover release of the line right after the turnaround boundary, sampling only while the line is released, and a stable upper frame register while busy.

Only the bench's scenarios can show the end-to-end behaviour. That covers the exact bit sequence, the frame length in clocks for each divider setting, the latching of the divider select, and the returned read value. It also covers the ignored writes, both while disabled and while busy, and the correct resumption after a pause.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   localparam int FRAME_W  = 32;
   localparam int DATA_W   = 16;
   localparam int OP_LSB   = 28;
   localparam int TA_MSB   = 17;

   typedef enum logic [1:0] {
      OP_RSVD_A = 2'b00,
      OP_WRITE  = 2'b01,
      OP_READ   = 2'b10,
      OP_RSVD_B = 2'b11
   } mdio_op_e;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
   parameter int BASE_DIV = 8,
   parameter int SEL_W    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [SEL_W-1:0] sel,
   input  logic             run,
   output logic             mdc,
   output logic             rise_tick,
   output logic             fall_tick
);
   localparam int NSEL     = 1 << SEL_W;
   localparam int MAX_HALF = (BASE_DIV << (NSEL - 1)) / 2;
   localparam int CW       = (MAX_HALF > 1) ? $clog2(MAX_HALF) : 1;

   initial begin
      assert (BASE_DIV >= 2 && (BASE_DIV & (BASE_DIV - 1)) == 0)
         else $error("BASE_DIV must be a power of two of at least 2");
      assert (SEL_W >= 1) else $error("SEL_W must be at least 1");
   end

   logic [CW-1:0]    last_cnt [NSEL];
   logic [CW-1:0]    cnt;
   logic [SEL_W-1:0] sel_q;
   logic             tick;

   for (genvar g = 0; g < NSEL; g++) begin : g_half
      assign last_cnt[g] = CW'(((BASE_DIV << g) / 2) - 1);
   end

   assign tick      = run && (cnt == last_cnt[sel_q]);
   assign rise_tick = tick && !mdc;
   assign fall_tick = tick && mdc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         mdc   <= 1'b0;
         sel_q <= '0;
      end else if (start) begin
         cnt   <= '0;
         mdc   <= 1'b0;
         sel_q <= sel;
      end else if (run) begin
         if (tick) begin
            cnt <= '0;
            mdc <= ~mdc;
         end else begin
            cnt <= cnt + CW'(1);
         end
      end
   end

   // R11: a paused engine holds its clock
   p_mdc_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !start) |=> $stable(mdc));
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
   import mdio_pkg::*;
#(
   parameter int PRE_BITS = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mgmt_en,
   input  logic               frame_wr,
   input  logic [FRAME_W-1:0] frame_wdata,
   input  logic               rise_tick,
   input  logic               fall_tick,
   input  logic               mdio_i,
   output logic               busy,
   output logic               start,
   output logic [FRAME_W-1:0] frame_q,
   output logic               mdio_o,
   output logic               mdio_oe
);
   localparam int TOTAL    = PRE_BITS + FRAME_W;
   localparam int IW       = $clog2(TOTAL);
   localparam int TA_IDX   = PRE_BITS + (FRAME_W - 1 - TA_MSB);
   localparam int DATA_IDX = PRE_BITS + FRAME_W - DATA_W;

   initial begin
      assert (PRE_BITS >= 0 && PRE_BITS <= 64)
         else $error("PRE_BITS out of range");
   end

   logic [IW-1:0] idx;
   logic          in_pre;
   logic          is_read;
   logic          last_bit;
   logic          in_data;
   logic [4:0]    bpos;

   if (PRE_BITS > 0) begin : g_pre
      assign in_pre = idx < IW'(PRE_BITS);
   end else begin : g_nopre
      assign in_pre = 1'b0;
   end

   assign start    = frame_wr && mgmt_en && !busy;
   assign is_read  = frame_q[OP_LSB+1:OP_LSB] == OP_READ;
   assign last_bit = idx == IW'(TOTAL - 1);
   assign in_data  = idx >= IW'(DATA_IDX);

   always_comb begin
      bpos = 5'(FRAME_W - 1 - (int'(idx) - PRE_BITS));
   end

   assign mdio_o  = busy && (in_pre || frame_q[bpos]);
   assign mdio_oe = busy && !(is_read && idx >= IW'(TA_IDX));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         idx     <= '0;
         frame_q <= '0;
      end else if (start) begin
         busy    <= 1'b1;
         idx     <= '0;
         frame_q <= frame_wdata;
      end else if (busy) begin
         if (rise_tick && is_read && in_data) begin
            frame_q[DATA_W-1:0] <= {frame_q[DATA_W-2:0], mdio_i};
         end
         if (fall_tick) begin
            if (last_bit) begin
               busy <= 1'b0;
               idx  <= '0;
            end else begin
               idx  <= idx + IW'(1);
            end
         end
      end
   end

   // R6: bit position only advances on a falling clock tick
   p_bit_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !fall_tick |=> $stable(idx));
   // R8: line released right after the last address bit of a read
   p_ta_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && is_read && fall_tick && idx == IW'(TA_IDX - 1)) |=> !mdio_oe);
   // R9: sampling happens only with the line released
   p_capture_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rise_tick && is_read && in_data) |-> !mdio_oe);
   // R4: header of a running frame cannot be overwritten
   p_header_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(frame_q[FRAME_W-1:DATA_W]));
   // R2: an accepted launch makes the engine busy
   p_launch_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
   import mdio_pkg::*;
#(
   parameter int BASE_DIV = 8,
   parameter int SEL_W    = 2,
   parameter int PRE_BITS = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mgmt_en,
   input  logic [SEL_W-1:0] clk_div_sel,
   input  logic             frame_wr,
   input  logic [31:0]      frame_wdata,
   output logic [31:0]      frame_q,
   output logic             idle,
   output logic             mdc,
   output logic             mdio_o,
   output logic             mdio_oe,
   input  logic             mdio_i
);
   logic busy;
   logic start;
   logic run;
   logic rise_tick;
   logic fall_tick;

   assign run  = busy && mgmt_en;
   assign idle = !busy;

   mdio_clk_div #(
      .BASE_DIV (BASE_DIV),
      .SEL_W    (SEL_W)
   ) i_clk_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .sel       (clk_div_sel),
      .run       (run),
      .mdc       (mdc),
      .rise_tick (rise_tick),
      .fall_tick (fall_tick)
   );

   mdio_shifter #(
      .PRE_BITS (PRE_BITS)
   ) i_shifter (
      .clk         (clk),
      .rst_n       (rst_n),
      .mgmt_en     (mgmt_en),
      .frame_wr    (frame_wr),
      .frame_wdata (frame_wdata),
      .rise_tick   (rise_tick),
      .fall_tick   (fall_tick),
      .mdio_i      (mdio_i),
      .busy        (busy),
      .start       (start),
      .frame_q     (frame_q),
      .mdio_o      (mdio_o),
      .mdio_oe     (mdio_oe)
   );

   // R5: line and clock quiet while idle
   p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> (!mdc && !mdio_oe));
endmodule

// File: tb/test_mdio_frame_engine.sv
module test_mdio_frame_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mgmt_en = 1'b0;
   logic [1:0]  clk_div_sel = 2'd0;
   logic        frame_wr = 1'b0;
   logic [31:0] frame_wdata = '0;
   logic        mdio_i = 1'b1;
   logic [31:0] frame_q;
   logic        idle, mdc, mdio_o, mdio_oe;

   always #2 clk = ~clk;

   mdio_frame_engine i_mdio_frame_engine (
      .clk(clk), .rst_n(rst_n), .mgmt_en(mgmt_en), .clk_div_sel(clk_div_sel),
      .frame_wr(frame_wr), .frame_wdata(frame_wdata), .frame_q(frame_q),
      .idle(idle), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   int n_cmp = 0;
   int n_bad = 0;

   // behavioural reference state
   bit          m_busy = 0;
   bit          m_read = 0;
   int          m_t = 0;
   int          m_half = 4;
   logic [31:0] m_frame = '0;
   bit          m_bits[$];
   logic [15:0] resp_data = 16'h0;
   int          e_k;
   bit          e_mdc, e_oe;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy  = 0;
         m_t     = 0;
         m_frame = '0;
      end else if (m_busy) begin
         if (mgmt_en) begin
            m_t++;
            if (m_t == 128 * m_half) begin
               m_busy = 0;
               if (m_read) m_frame[15:0] = resp_data;
            end
         end
      end else if (frame_wr && mgmt_en) begin
         m_busy  = 1;
         m_t     = 0;
         m_half  = 4 << clk_div_sel;
         m_frame = frame_wdata;
         m_read  = (frame_wdata[29:28] == 2'b10);
         m_bits.delete();
         for (int i = 0; i < 32; i++) m_bits.push_back(1'b1);
         for (int b = 31; b >= 0; b--) m_bits.push_back(frame_wdata[b]);
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (m_busy) begin
            e_k   = m_t / (2 * m_half);
            e_mdc = ((m_t / m_half) % 2) == 1;
            e_oe  = !(m_read && e_k >= 46);
         end else begin
            e_k   = 0;
            e_mdc = 0;
            e_oe  = 0;
         end
         chk("R5 mdc", {31'b0, mdc}, {31'b0, e_mdc});
         chk("R10 idle", {31'b0, idle}, {31'b0, !m_busy});
         if (!m_busy) chk("R1 oe idle", {31'b0, mdio_oe}, 32'd0);
         else if (m_read) chk("R8 oe read", {31'b0, mdio_oe}, {31'b0, e_oe});
         else chk("R7 oe write", {31'b0, mdio_oe}, {31'b0, e_oe});
         if (m_busy && e_oe) chk("R6 mdio_o", {31'b0, mdio_o}, {31'b0, m_bits[e_k]});
         if (!m_busy) chk("R9 frame_q", frame_q, m_frame);
         if (m_busy && m_read && e_k >= 48) mdio_i = resp_data[15 - (e_k - 48)];
         else mdio_i = 1'b1;
      end
   end

   function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] phy,
                                       input logic [4:0] rg, input logic [15:0] d);
      return {2'b01, op, phy, rg, 2'b10, d};
   endfunction

   task automatic launch(input logic [31:0] w, input logic [1:0] s);
      @(negedge clk);
      frame_wdata = w;
      clk_div_sel = s;
      frame_wr    = 1'b1;
      @(negedge clk);
      frame_wr    = 1'b0;
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (!idle && n < 20000) begin
         @(negedge clk);
         n++;
      end
   endtask

   initial begin
      int n;
      logic [31:0] prev;
      logic held;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle", {31'b0, idle}, 32'd1);
      chk("R1 mdc", {31'b0, mdc}, 32'd0);
      chk("R1 oe", {31'b0, mdio_oe}, 32'd0);
      chk("R1 frame", frame_q, 32'd0);

      mgmt_en = 1'b1;
      launch(mk(2'b01, 5'd5, 5'd4, 16'hA5C3), 2'd0);
      chk("R2 launch", {31'b0, idle}, 32'd0);
      chk("R2 loaded", frame_q, mk(2'b01, 5'd5, 5'd4, 16'hA5C3));
      wait_idle(n);
      chk("R10 length div8", n, 64 * 8);

      resp_data = 16'hBEEF;
      launch(mk(2'b10, 5'd17, 5'd1, 16'h0000), 2'd1);
      wait_idle(n);
      chk("R10 length div16", n, 64 * 16);
      chk("R9 read data", frame_q, mk(2'b10, 5'd17, 5'd1, 16'hBEEF));

      mgmt_en = 1'b0;
      prev = frame_q;
      launch(mk(2'b01, 5'd3, 5'd9, 16'h1111), 2'd0);
      repeat (20) @(negedge clk);
      chk("R3 idle kept", {31'b0, idle}, 32'd1);
      chk("R3 frame kept", frame_q, prev);
      mgmt_en = 1'b1;

      launch(mk(2'b01, 5'd30, 5'd31, 16'h5A0F), 2'd2);
      repeat (100) @(negedge clk);
      frame_wdata = mk(2'b10, 5'd1, 5'd2, 16'hFFFF);
      clk_div_sel = 2'd0;
      frame_wr = 1'b1;
      @(negedge clk);
      frame_wr = 1'b0;
      wait_idle(n);
      chk("R5 divider latched", n + 101, 64 * 32);
      chk("R4 busy write ignored", frame_q, mk(2'b01, 5'd30, 5'd31, 16'h5A0F));

      resp_data = 16'h1234;
      launch(mk(2'b10, 5'd9, 5'd14, 16'hFFFF), 2'd3);
      repeat (300) @(negedge clk);
      mgmt_en = 1'b0;
      held = mdc;
      repeat (37) @(negedge clk);
      chk("R11 mdc held", {31'b0, mdc}, {31'b0, held});
      chk("R11 still busy", {31'b0, idle}, 32'd0);
      mgmt_en = 1'b1;
      wait_idle(n);
      chk("R11 resumed data", frame_q, mk(2'b10, 5'd9, 5'd14, 16'h1234));

      resp_data = 16'h8001;
      launch(mk(2'b10, 5'd0, 5'd0, 16'h0000), 2'd0);
      wait_idle(n);
      chk("R9 edge data", frame_q, mk(2'b10, 5'd0, 5'd0, 16'h8001));

      repeat (4) @(negedge clk);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule